// File: doc/BRIEF.md
# Deferred-Exception Poison Register File

This block is an integer register file in which every entry has a one-bit poison tag next to its data. A pipeline that hoists instructions above branches marks each hoisted result as speculative when it writes it back. The register file then decides what that write means. A speculative result that hit a terminating exception, such as a protection violation, is not reported. It is stored as a poisoned zero, and the fault is reported later, only if the value is consumed for real. A resumable exception, such as a page miss, asks for service straight away and never leaves poison behind.

Consumers read through parallel read ports. Each read port carries a flag that says whether the reading instruction is speculative. A non-speculative read of a poisoned entry raises a fault that names the register. A speculative read does not fault; it hands the tag back so that the consumer can pass the poison on to its own result. A separate check port stands where the hoisted instruction originally sat in program order. It tests one register and asks for recovery when that register is poisoned, and it never raises a fault.

Top module: `poison_regfile`

## Requirements
- R1: While `rst` is high, the poison tags are cleared. In the cycle after reset, `fault_valid`, `svc_valid`, `chk_done`, `chk_recover`, `rd_poison`, `rd_data`, `fault_idx` and `svc_idx` are all zero.
- R2: A write to a non-zero register with class 2'b00 (no exception) stores `wr_data` and clears the tag. A later enabled read returns that data with `rd_poison` low.
- R3: A speculative write (`wr_spec`=1) with a terminating class (2'b10 or 2'b11) stores zero with the tag set and raises no service request.
- R4: A write with the resumable class 2'b01, speculative or not, leaves the register unchanged. One cycle later it pulses `svc_valid` with `svc_fatal`=0 and `svc_idx` set to the written index.
- R5: A non-speculative write with a terminating class leaves the register unchanged. One cycle later it pulses `svc_valid` with `svc_fatal`=1 and `svc_idx` set to the written index.
- R6: A speculative clean write with `wr_src_poison`=1 stores zero with the tag set. A non-speculative clean write ignores `wr_src_poison` and clears the tag.
- R7: An enabled read returns data and tag one cycle later. If the read is non-speculative and the tag is set, `fault_valid` pulses one cycle later with `fault_idx` set to the register read. A speculative read never faults.
- R8: `chk_en` produces `chk_done` one cycle later, with `chk_recover` equal to the tag of `chk_idx`. A check never raises a fault.
- R9: Register 0 always reads as zero with the tag clear. A write to register 0 changes nothing and raises no service request.
- R10: If a read or a check names the register being written in the same cycle, it returns the newly written data and tag.
- R11: When several read ports fault in the same cycle, `fault_idx` reports the register read by the lowest-numbered faulting port.
- R12: When a read port is not enabled, its `rd_data` and `rd_poison` keep their previous values. Between pulses, `fault_idx` and `svc_idx` also keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | IW | Destination register |
| wr_data | input | XLEN | Result data |
| wr_spec | input | 1 | Producer is speculative |
| wr_src_poison | input | 1 | A source of the producer was poisoned |
| wr_exc | input | 2 | Exception class: 00 none, 01 resumable, 1x terminating |
| rd_en | input | NRD | Per-port read enable |
| rd_spec | input | NRD | Per-port consumer is speculative |
| rd_idx | input | NRD*IW | Per-port register index, port p at bits [p*IW +: IW] |
| rd_data | output | NRD*XLEN | Per-port read data, port p at bits [p*XLEN +: XLEN] |
| rd_poison | output | NRD | Per-port poison tag |
| fault_valid | output | 1 | Non-speculative use of poison |
| fault_idx | output | IW | Register that caused the fault |
| svc_valid | output | 1 | Exception needs service now |
| svc_fatal | output | 1 | Serviced exception is terminating |
| svc_idx | output | IW | Destination of the excepting write |
| chk_en | input | 1 | Check instruction valid |
| chk_idx | input | IW | Register under check |
| chk_done | output | 1 | Check result valid |
| chk_recover | output | 1 | Recovery requested |

## Verification
Every result appears exactly one clock edge after the inputs that cause it: read data and tags, faults, service requests and check results alike. A write that shares a cycle with a read of the same register shows up in that same one-cycle result. The bench drives inputs on the falling edge and updates its own model of registers and tags from the requirements, letting that cycle's write go ahead of that cycle's reads. It then waits for the next rising edge and compares every output on the falling edge that follows. Randomly mixed writes, reads and checks run alongside directed cases for poisoning, propagation, register zero, bypass and port priority.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'b00,
    EXC_RESUME   = 2'b01,
    EXC_TERM     = 2'b10,
    EXC_TERM_ALT = 2'b11
  } exc_e;

  function automatic logic is_terminating(input logic [1:0] cls);
    return cls[1];
  endfunction

endpackage

// File: rtl/prf_write_ctrl.sv
module prf_write_ctrl
  import prf_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_spec,
  input  logic            wr_src_poison,
  input  logic [1:0]      wr_exc,
  output logic            commit_en,
  output logic [IW-1:0]   commit_idx,
  output logic [XLEN-1:0] commit_data,
  output logic            commit_poison,
  output logic            svc_valid,
  output logic            svc_fatal,
  output logic [IW-1:0]   svc_idx
);

  logic live;
  logic svc_now;
  logic fatal_now;
  exc_e cls;

  assign live       = wr_en && (wr_idx != '0);
  assign cls        = exc_e'(wr_exc);
  assign commit_idx = wr_idx;

  always_comb begin
    commit_en     = 1'b0;
    commit_poison = 1'b0;
    svc_now       = 1'b0;
    fatal_now     = 1'b0;
    if (live) begin
      unique case (cls)
        EXC_NONE: begin
          commit_en     = 1'b1;
          commit_poison = wr_spec & wr_src_poison;
        end
        EXC_RESUME: begin
          svc_now = 1'b1;
        end
        default: begin
          if (wr_spec) begin
            commit_en     = 1'b1;
            commit_poison = 1'b1;
          end else begin
            svc_now   = 1'b1;
            fatal_now = is_terminating(wr_exc);
          end
        end
      endcase
    end
    commit_data = commit_poison ? '0 : wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_valid <= 1'b0;
      svc_fatal <= 1'b0;
      svc_idx   <= '0;
    end else begin
      svc_valid <= svc_now;
      svc_fatal <= svc_now & fatal_now;
      if (svc_now) svc_idx <= wr_idx;
    end
  end

endmodule

// File: rtl/prf_storage.sv
module prf_storage #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_en,
  input  logic [IW-1:0]     commit_idx,
  input  logic [XLEN-1:0]   commit_data,
  input  logic              commit_poison,
  input  logic [NRD-1:0]    rd_en,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*XLEN-1:0] rd_data,
  output logic [NRD-1:0]    rd_poison,
  output logic [NRD-1:0]    port_poison,
  input  logic [IW-1:0]     chk_idx,
  output logic              chk_poison
);

  logic [XLEN-1:0]  mem [NREGS];
  logic [NREGS-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (commit_en) mem[commit_idx] <= commit_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (commit_en) begin
      tag_q[commit_idx] <= commit_poison;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [IW-1:0]   idx;
    logic            hit;
    logic            zero;
    logic [XLEN-1:0] eff_data;
    logic            eff_tag;
    logic [XLEN-1:0] data_q;
    logic            tag_out_q;

    assign idx  = rd_idx[p*IW +: IW];
    assign zero = (idx == '0);
    assign hit  = commit_en && (commit_idx == idx);

    always_comb begin
      if (zero) begin
        eff_data = '0;
        eff_tag  = 1'b0;
      end else if (hit) begin
        eff_data = commit_data;
        eff_tag  = commit_poison;
      end else begin
        eff_data = mem[idx];
        eff_tag  = tag_q[idx];
      end
    end

    assign port_poison[p] = eff_tag;

    always_ff @(posedge clk) begin
      if (rst) begin
        data_q    <= '0;
        tag_out_q <= 1'b0;
      end else if (rd_en[p]) begin
        data_q    <= eff_data;
        tag_out_q <= eff_tag;
      end
    end

    assign rd_data[p*XLEN +: XLEN] = data_q;
    assign rd_poison[p]            = tag_out_q;
  end

  always_comb begin
    if (chk_idx == '0)
      chk_poison = 1'b0;
    else if (commit_en && (commit_idx == chk_idx))
      chk_poison = commit_poison;
    else
      chk_poison = tag_q[chk_idx];
  end

endmodule

// File: rtl/prf_sentinel.sv
module prf_sentinel #(
  parameter int NREGS = 32,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NRD-1:0]    rd_en,
  input  logic [NRD-1:0]    rd_spec,
  input  logic [NRD*IW-1:0] rd_idx,
  input  logic [NRD-1:0]    port_poison,
  input  logic              chk_en,
  input  logic              chk_poison,
  output logic              fault_valid,
  output logic [IW-1:0]     fault_idx,
  output logic              chk_done,
  output logic              chk_recover
);

  logic [NRD-1:0] bad;
  logic           any_bad;
  logic [IW-1:0]  sel_idx;

  assign bad     = rd_en & ~rd_spec & port_poison;
  assign any_bad = |bad;

  always_comb begin
    sel_idx = '0;
    for (int p = NRD - 1; p >= 0; p--) begin
      if (bad[p]) sel_idx = rd_idx[p*IW +: IW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid <= 1'b0;
      fault_idx   <= '0;
      chk_done    <= 1'b0;
      chk_recover <= 1'b0;
    end else begin
      fault_valid <= any_bad;
      if (any_bad) fault_idx <= sel_idx;
      chk_done    <= chk_en;
      chk_recover <= chk_en & chk_poison;
    end
  end

endmodule

// File: rtl/poison_regfile.sv
module poison_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [XLEN-1:0]     wr_data,
  input  logic                wr_spec,
  input  logic                wr_src_poison,
  input  logic [1:0]          wr_exc,
  input  logic [NRD-1:0]      rd_en,
  input  logic [NRD-1:0]      rd_spec,
  input  logic [NRD*IW-1:0]   rd_idx,
  output logic [NRD*XLEN-1:0] rd_data,
  output logic [NRD-1:0]      rd_poison,
  output logic                fault_valid,
  output logic [IW-1:0]       fault_idx,
  output logic                svc_valid,
  output logic                svc_fatal,
  output logic [IW-1:0]       svc_idx,
  input  logic                chk_en,
  input  logic [IW-1:0]       chk_idx,
  output logic                chk_done,
  output logic                chk_recover
);

  logic            commit_en;
  logic [IW-1:0]   commit_idx;
  logic [XLEN-1:0] commit_data;
  logic            commit_poison;
  logic [NRD-1:0]  port_poison;
  logic            chk_poison;

  prf_write_ctrl #(.NREGS(NREGS), .XLEN(XLEN)) u_wr (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .wr_spec       (wr_spec),
    .wr_src_poison (wr_src_poison),
    .wr_exc        (wr_exc),
    .commit_en     (commit_en),
    .commit_idx    (commit_idx),
    .commit_data   (commit_data),
    .commit_poison (commit_poison),
    .svc_valid     (svc_valid),
    .svc_fatal     (svc_fatal),
    .svc_idx       (svc_idx)
  );

  prf_storage #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) u_mem (
    .clk           (clk),
    .rst           (rst),
    .commit_en     (commit_en),
    .commit_idx    (commit_idx),
    .commit_data   (commit_data),
    .commit_poison (commit_poison),
    .rd_en         (rd_en),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .rd_poison     (rd_poison),
    .port_poison   (port_poison),
    .chk_idx       (chk_idx),
    .chk_poison    (chk_poison)
  );

  prf_sentinel #(.NREGS(NREGS), .NRD(NRD)) u_sent (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_spec     (rd_spec),
    .rd_idx      (rd_idx),
    .port_poison (port_poison),
    .chk_en      (chk_en),
    .chk_poison  (chk_poison),
    .fault_valid (fault_valid),
    .fault_idx   (fault_idx),
    .chk_done    (chk_done),
    .chk_recover (chk_recover)
  );

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREGS)
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [IW-1:0]       wr_idx,
  input logic                wr_spec,
  input logic [1:0]          wr_exc,
  input logic [NRD-1:0]      rd_en,
  input logic [NRD-1:0]      rd_spec,
  input logic [NRD*IW-1:0]   rd_idx,
  input logic [NRD*XLEN-1:0] rd_data,
  input logic [NRD-1:0]      rd_poison,
  input logic                fault_valid,
  input logic                svc_valid,
  input logic                svc_fatal,
  input logic [IW-1:0]       svc_idx,
  input logic                chk_en,
  input logic                chk_done
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!fault_valid && !svc_valid && !chk_done));

  a_r3_spec_term_silent: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_spec && wr_exc[1]) |=> !svc_valid);

  a_r5_fatal_service: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx != '0) && !wr_spec && wr_exc[1])
      |=> (svc_valid && svc_fatal && (svc_idx == $past(wr_idx))));

  a_r4_resume_service: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx != '0) && (wr_exc == 2'b01))
      |=> (svc_valid && !svc_fatal));

  a_r7_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> $past(|(rd_en & ~rd_spec)));

  a_r8_check_done: assert property (@(posedge clk) disable iff (rst)
    chk_en |=> chk_done);

  a_r8_check_never_faults: assert property (@(posedge clk) disable iff (rst)
    (chk_en && (rd_en == '0)) |=> !fault_valid);

  a_r9_zero_reads_clean: assert property (@(posedge clk) disable iff (rst)
    (rd_en[0] && (rd_idx[IW-1:0] == '0))
      |=> ((rd_data[XLEN-1:0] == '0) && !rd_poison[0]));

endmodule

bind poison_regfile prf_checker #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) u_prf_checker (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_spec     (wr_spec),
  .wr_exc      (wr_exc),
  .rd_en       (rd_en),
  .rd_spec     (rd_spec),
  .rd_idx      (rd_idx),
  .rd_data     (rd_data),
  .rd_poison   (rd_poison),
  .fault_valid (fault_valid),
  .svc_valid   (svc_valid),
  .svc_fatal   (svc_fatal),
  .svc_idx     (svc_idx),
  .chk_en      (chk_en),
  .chk_done    (chk_done)
);

// File: tb/test_poison_regfile.sv
`timescale 1ns/1ps
module test_poison_regfile;

  localparam int NREGS = 32;
  localparam int XLEN  = 32;
  localparam int NRD   = 2;
  localparam int IW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_spec = 0, wr_src_poison = 0, chk_en = 0;
  logic [IW-1:0] wr_idx = '0, chk_idx = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic [1:0] wr_exc = 2'b00;
  logic [NRD-1:0] rd_en = '0, rd_spec = '0;
  logic [NRD*IW-1:0] rd_idx = '0;
  logic [NRD*XLEN-1:0] rd_data;
  logic [NRD-1:0] rd_poison;
  logic fault_valid, svc_valid, svc_fatal, chk_done, chk_recover;
  logic [IW-1:0] fault_idx, svc_idx;

  always #2.5 clk = ~clk;

  poison_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) i_poison_regfile (.*);

  int nchk = 0, nfail = 0;

  logic [XLEN-1:0] m_data [NREGS];
  logic            m_tag  [NREGS];
  logic [XLEN-1:0] e_rd_data [NRD];
  logic            e_rd_tag  [NRD];
  logic e_fv = 0, e_sv = 0, e_sf = 0, e_cd = 0, e_cr = 0;
  logic [IW-1:0] e_fi = '0, e_si = '0;

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NREGS; r++) m_tag[r] = 1'b0;
    for (int p = 0; p < NRD; p++) begin e_rd_data[p] = '0; e_rd_tag[p] = 1'b0; end
    e_fv = 0; e_sv = 0; e_sf = 0; e_cd = 0; e_cr = 0; e_fi = '0; e_si = '0;
  endtask

  task automatic predict();
    logic live;
    logic bad;
    live = wr_en && (wr_idx != 0);
    e_sv = 1'b0; e_sf = 1'b0;
    if (live) begin
      if (wr_exc == 2'b00) begin
        m_tag[wr_idx]  = wr_spec && wr_src_poison;
        m_data[wr_idx] = m_tag[wr_idx] ? '0 : wr_data;
      end else if (wr_exc == 2'b01) begin
        e_sv = 1; e_si = wr_idx;
      end else if (wr_spec) begin
        m_tag[wr_idx] = 1'b1; m_data[wr_idx] = '0;
      end else begin
        e_sv = 1; e_sf = 1; e_si = wr_idx;
      end
    end
    bad = 1'b0;
    for (int p = 0; p < NRD; p++) begin
      logic [IW-1:0] ix;
      ix = rd_idx[p*IW +: IW];
      if (rd_en[p]) begin
        e_rd_data[p] = (ix == 0) ? '0 : m_data[ix];
        e_rd_tag[p]  = (ix == 0) ? 1'b0 : m_tag[ix];
        if (!rd_spec[p] && e_rd_tag[p] && !bad) begin bad = 1; e_fi = ix; end
      end
    end
    e_fv = bad;
    e_cd = chk_en;
    e_cr = chk_en && (chk_idx != 0) && m_tag[chk_idx];
  endtask

  task automatic compare(string req);
    for (int p = 0; p < NRD; p++) begin
      check(req, $sformatf("rd_data[%0d]", p), rd_data[p*XLEN +: XLEN], e_rd_data[p]);
      check(req, $sformatf("rd_poison[%0d]", p), XLEN'(rd_poison[p]), XLEN'(e_rd_tag[p]));
    end
    check(req, "fault_valid", XLEN'(fault_valid), XLEN'(e_fv));
    check(req, "fault_idx",   XLEN'(fault_idx),   XLEN'(e_fi));
    check(req, "svc_valid",   XLEN'(svc_valid),   XLEN'(e_sv));
    check(req, "svc_fatal",   XLEN'(svc_fatal),   XLEN'(e_sf));
    check(req, "svc_idx",     XLEN'(svc_idx),     XLEN'(e_si));
    check(req, "chk_done",    XLEN'(chk_done),    XLEN'(e_cd));
    check(req, "chk_recover", XLEN'(chk_recover), XLEN'(e_cr));
  endtask

  task automatic step(string req);
    predict();
    @(posedge clk);
    @(negedge clk);
    compare(req);
    wr_en = 0; rd_en = '0; rd_spec = '0; chk_en = 0; wr_spec = 0; wr_src_poison = 0; wr_exc = 2'b00;
  endtask

  task automatic setw(logic [IW-1:0] i, logic [XLEN-1:0] d, logic s, logic sp, logic [1:0] x);
    wr_en = 1; wr_idx = i; wr_data = d; wr_spec = s; wr_src_poison = sp; wr_exc = x;
  endtask

  task automatic setr(int p, logic [IW-1:0] i, logic s);
    rd_en[p] = 1; rd_spec[p] = s; rd_idx[p*IW +: IW] = i;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1");

    for (int r = 1; r < NREGS; r++) begin
      setw(IW'(r), 32'h0101_0101 * r, 0, 0, 2'b00);
      step("R2");
    end
    setr(0, 5, 0); setr(1, 31, 0); step("R2");

    setw(7, 32'hDEAD_BEEF, 1, 0, 2'b10); step("R3");
    setr(0, 7, 1); setr(1, 7, 1); step("R3");
    setr(1, 7, 0); step("R7");
    chk_en = 1; chk_idx = 7; step("R8");
    chk_en = 1; chk_idx = 5; step("R8");

    setw(5, 32'h1234_5678, 1, 0, 2'b01); setr(0, 5, 0); step("R4");
    setw(6, 32'h1111_2222, 0, 0, 2'b11); step("R5");
    setr(0, 6, 0); step("R5");

    setw(9, 32'hABCD_0000, 1, 1, 2'b00); step("R6");
    setr(0, 9, 1); step("R6");
    setw(7, 32'h7777_7777, 0, 1, 2'b00); setr(1, 7, 0); step("R6");

    setw(0, 32'hFFFF_FFFF, 1, 0, 2'b10); setr(0, 0, 0); step("R9");
    setr(0, 0, 0); chk_en = 1; chk_idx = 0; step("R9");

    setw(12, 32'hCAFE_F00D, 0, 0, 2'b00); setr(0, 12, 0); chk_en = 1; chk_idx = 12; step("R10");
    setw(13, 32'h0, 1, 0, 2'b10); setr(1, 13, 1); chk_en = 1; chk_idx = 13; step("R10");

    setw(3, 32'h0, 1, 0, 2'b10); step("R11");
    setr(0, 9, 0); setr(1, 3, 0); step("R11");
    setr(0, 3, 0); setr(1, 9, 0); step("R11");
    setr(0, 13, 1); setr(1, 9, 0); step("R11");
    step("R12");

    for (int n = 0; n < 3000; n++) begin
      int x;
      x = $urandom_range(0, 9);
      if ($urandom_range(0, 2) != 0)
        setw(IW'($urandom), $urandom, 1'($urandom), 1'($urandom),
             (x < 5) ? 2'b00 : (x < 7) ? 2'b01 : 2'($urandom_range(2, 3)));
      for (int p = 0; p < NRD; p++)
        if ($urandom_range(0, 1) != 0) setr(p, IW'($urandom), 1'($urandom));
      if ($urandom_range(0, 3) == 0) begin chk_en = 1; chk_idx = IW'($urandom); end
      step("R12");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule